// File: doc/BRIEF.md
# Wave Issue Scheduler with Register-Bank Read Arbitration

This block is the issue stage of a GPU compute unit. It serves a set of execution pipes: `N_SIMD` vector pipes followed by `N_MEM` memory pipes. Each pipe keeps its own set of ready waves. Waves enter that set through a per-pipe insertion mask. Every cycle, each pipe whose set is non-empty chooses one wave in round-robin order and places it in its dispatch slot. A pipe with nothing ready keeps whatever its slot already holds.

Once all pipes have chosen, a second pass protects the vector register file read ports. Each occupied memory slot is compared against the other occupied slots. If a wave on the same SIMD reads from the same register bank, the other slot is cancelled: its slot is emptied, the wave goes back to the ready state, and it returns to its pipe's ready set so it can compete again. Write ports are not checked, because a store never writes the register file and load returns are arbitrated elsewhere.

The outputs are the registered dispatch slots (valid, wave id, SIMD id) and a per-wave blocked flag.

Top module: `wave_issue_sched`

## Requirements
- R1: Wave id `w` lives on SIMD `w / SLOTS`, slot `w % SLOTS`, and bank `(w % SLOTS) % BANKS`. Pipe `p` owns insertion bits `rdy_set[p*W +: W]`. Pipes `0..N_SIMD-1` are vector pipes and the rest are memory pipes. A bit set in `rdy_set` joins the pipe's ready set at the next clock edge, and a choice made from that set appears on the dispatch outputs one edge later. With nothing ready, no slot is ever filled.
- R2: A pipe chooses the first ready wave after the wave it chose last, searching upward in id and wrapping. After reset the search starts at id 0.
- R3: A pipe whose ready set is empty leaves its dispatch slot (valid and wave) unchanged, unless that slot is cancelled by R5.
- R4: A chosen wave leaves its pipe's ready set and its `wave_blk` bit goes to 1. An insertion of a wave through `rdy_set` clears its `wave_blk` bit.
- R5: If an occupied memory slot and another occupied slot hold waves of the same SIMD and the same bank, the other slot is cancelled. That slot shows valid 0 and wave 0, and the cancelled wave's `wave_blk` bit is 0.
- R6: Waves on different SIMDs, or on different banks of one SIMD, never cancel each other.
- R7: A memory pipe cancels at most one slot per cycle. It takes the lowest-index conflicting slot.
- R8: Memory pipes are processed in ascending index order. A slot already cancelled in the cycle is ignored by later memory pipes, and a lower memory pipe may cancel a higher memory pipe's slot.
- R9: A cancelled wave returns to its pipe's ready set and may be chosen again in a later cycle.
- R10: Reset (synchronous, active low) empties all ready sets and slots and clears all `wave_blk` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rdy_set | input | (N_SIMD+N_MEM)*W | Per-pipe wave insertion masks |
| disp_vld | output | N_SIMD+N_MEM | Dispatch slot filled, one bit per pipe |
| disp_wave | output | (N_SIMD+N_MEM)*IDW | Wave id held in each slot |
| disp_simd | output | (N_SIMD+N_MEM)*SIDW | SIMD of the wave in each slot |
| wave_blk | output | W | Per-wave blocked flag |

## Verification
The bench targets three kinds of cancellation:
- A chain in which one memory pipe cancels another's slot. A design that cancelled both, or kept the later slot, would show the wrong memory pipe valid.
- Two vector slots that both conflict with one memory pick. A design that cancelled both would empty an extra slot.
- A cancelled slot that is ignored by the next memory pipe. A design that did not ignore it would let that pipe skip its own conflict.

Round-robin wrap and the return of a cancelled wave are checked across several cycles. A pointer that did not wrap, or a wave that was lost on cancellation, would give the wrong id in a later slot. Held slots are checked against pipes whose ready set has drained. A design that cleared them would drop valid.

// File: rtl/wis_pkg.sv
package wis_pkg;

    function automatic int simd_of(int wave, int slots);
        return wave / slots;
    endfunction

    function automatic int bank_of(int wave, int slots, int banks);
        return (wave % slots) % banks;
    endfunction

endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
    parameter int W   = 16,
    parameter int IDW = 4
) (
    input  logic [W-1:0]   ready,
    input  logic [IDW-1:0] last,
    output logic           found,
    output logic [IDW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= W; k++) begin
            if (!found && ready[(int'(last) + k) % W]) begin
                found = 1'b1;
                idx   = IDW'((int'(last) + k) % W);
            end
        end
    end
endmodule

// File: rtl/wis_vrf_arb.sv
module wis_vrf_arb #(
    parameter int P      = 4,
    parameter int N_SIMD = 2,
    parameter int SLOTS  = 8,
    parameter int BANKS  = 2,
    parameter int IDW    = 4
) (
    input  logic [P-1:0]          cand_vld,
    input  logic [P-1:0][IDW-1:0] cand_wave,
    output logic [P-1:0]          drop
);
    import wis_pkg::*;

    logic [P-1:0] alive;
    logic         done;

    always_comb begin
        alive = cand_vld;
        drop  = '0;
        done  = 1'b0;
        for (int m = N_SIMD; m < P; m++) begin
            done = 1'b0;
            if (alive[m]) begin
                for (int i = 0; i < P; i++) begin
                    if (!done && i != m && alive[i]
                        && simd_of(int'(cand_wave[i]), SLOTS) == simd_of(int'(cand_wave[m]), SLOTS)
                        && bank_of(int'(cand_wave[i]), SLOTS, BANKS) == bank_of(int'(cand_wave[m]), SLOTS, BANKS)) begin
                        alive[i] = 1'b0;
                        drop[i]  = 1'b1;
                        done     = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched #(
    parameter int N_SIMD = 2,
    parameter int N_MEM  = 2,
    parameter int SLOTS  = 8,
    parameter int BANKS  = 2,
    localparam int P     = N_SIMD + N_MEM,
    localparam int W     = N_SIMD * SLOTS,
    localparam int IDW   = $clog2(W),
    localparam int SIDW  = (N_SIMD > 1) ? $clog2(N_SIMD) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [P*W-1:0]    rdy_set,
    output logic [P-1:0]      disp_vld,
    output logic [P*IDW-1:0]  disp_wave,
    output logic [P*SIDW-1:0] disp_simd,
    output logic [W-1:0]      wave_blk
);
    typedef struct packed {
        logic [P-1:0][W-1:0]   ready;
        logic [P-1:0][IDW-1:0] last;
        logic [P-1:0]          fill;
        logic [P-1:0][IDW-1:0] wave;
        logic [W-1:0]          blk;
    } state_t;

    state_t st_q, st_d;

    logic [P-1:0]          fnd;
    logic [P-1:0][IDW-1:0] pidx;
    logic [P-1:0]          cand_vld;
    logic [P-1:0][IDW-1:0] cand_wave;
    logic [P-1:0]          drop;
    logic [W-1:0]          set_any;
    logic [P*W-1:0]        ready_flat;
    logic [P*IDW-1:0]      pidx_flat;

    for (genvar p = 0; p < P; p++) begin : g_pipe
        wis_rr_pick #(.W(W), .IDW(IDW)) u_pick (
            .ready (st_q.ready[p]),
            .last  (st_q.last[p]),
            .found (fnd[p]),
            .idx   (pidx[p])
        );
        assign cand_vld[p]  = fnd[p] | st_q.fill[p];
        assign cand_wave[p] = fnd[p] ? pidx[p] : st_q.wave[p];
        assign disp_vld[p]  = st_q.fill[p];
        assign disp_wave[p*IDW +: IDW]   = st_q.wave[p];
        assign disp_simd[p*SIDW +: SIDW] = SIDW'(int'(st_q.wave[p]) / SLOTS);
        assign ready_flat[p*W +: W]      = st_q.ready[p];
        assign pidx_flat[p*IDW +: IDW]   = pidx[p];
    end

    wis_vrf_arb #(
        .P(P), .N_SIMD(N_SIMD), .SLOTS(SLOTS), .BANKS(BANKS), .IDW(IDW)
    ) u_arb (
        .cand_vld  (cand_vld),
        .cand_wave (cand_wave),
        .drop      (drop)
    );

    always_comb begin
        set_any = '0;
        for (int p = 0; p < P; p++) begin
            set_any = set_any | rdy_set[p*W +: W];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.blk = st_q.blk & ~set_any;
        for (int p = 0; p < P; p++) begin
            if (fnd[p]) begin
                st_d.ready[p][pidx[p]] = 1'b0;
                st_d.last[p]           = pidx[p];
            end
            if (drop[p]) begin
                st_d.ready[p][cand_wave[p]] = 1'b1;
                st_d.fill[p]                = 1'b0;
                st_d.wave[p]                = '0;
            end else if (fnd[p]) begin
                st_d.fill[p]          = 1'b1;
                st_d.wave[p]          = pidx[p];
                st_d.blk[pidx[p]]     = 1'b1;
            end
            st_d.ready[p] = st_d.ready[p] | rdy_set[p*W +: W];
        end
        for (int p = 0; p < P; p++) begin
            if (drop[p]) begin
                st_d.blk[cand_wave[p]] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ready <= '0;
            st_q.last  <= {P{IDW'(W-1)}};
            st_q.fill  <= '0;
            st_q.wave  <= '0;
            st_q.blk   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wave_blk = st_q.blk;
endmodule

// File: rtl/wave_issue_sched_chk.sv
module wave_issue_sched_chk #(
    parameter int P     = 4,
    parameter int W     = 16,
    parameter int IDW   = 4,
    parameter int N_MEM = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [P*W-1:0]   rdy_set,
    input logic [P*W-1:0]   ready_flat,
    input logic [P-1:0]     fnd,
    input logic [P*IDW-1:0] pidx_flat,
    input logic [P-1:0]     drop,
    input logic [P-1:0]     disp_vld,
    input logic [P*IDW-1:0] disp_wave
);
    a_r7_one_drop_per_mem: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drop) <= N_MEM);

    for (genvar p = 0; p < P; p++) begin : g_chk
        a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (ready_flat[p*W +: W] == '0 && !drop[p])
            |=> ($stable(disp_vld[p]) && $stable(disp_wave[p*IDW +: IDW])));

        a_r5_drop_empties: assert property (@(posedge clk) disable iff (!rst_n)
            drop[p] |=> !disp_vld[p]);

        a_r4_pick_removed: assert property (@(posedge clk) disable iff (!rst_n)
            (fnd[p] && !drop[p] && !rdy_set[p*W + int'(pidx_flat[p*IDW +: IDW])])
            |=> !ready_flat[p*W + int'($past(pidx_flat[p*IDW +: IDW]))]);

        a_r9_drop_reinserted: assert property (@(posedge clk) disable iff (!rst_n)
            (drop[p] && fnd[p])
            |=> ready_flat[p*W + int'($past(pidx_flat[p*IDW +: IDW]))]);
    end
endmodule

bind wave_issue_sched wave_issue_sched_chk #(
    .P(P), .W(W), .IDW(IDW), .N_MEM(N_MEM)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdy_set    (rdy_set),
    .ready_flat (ready_flat),
    .fnd        (fnd),
    .pidx_flat  (pidx_flat),
    .drop       (drop),
    .disp_vld   (disp_vld),
    .disp_wave  (disp_wave)
);

// File: tb/wave_issue_sched_bench.sv
`timescale 1ns/1ps
module wave_issue_sched_bench;
    localparam int P = 4;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [P*W-1:0] rdy_set = '0;
    logic [P-1:0]  disp_vld;
    logic [15:0]   disp_wave;
    logic [3:0]    disp_simd;
    logic [W-1:0]  wave_blk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    wave_issue_sched u_wave_issue_sched (
        .clk(clk), .rst_n(rst_n), .rdy_set(rdy_set),
        .disp_vld(disp_vld), .disp_wave(disp_wave),
        .disp_simd(disp_simd), .wave_blk(wave_blk)
    );

    // row = {rdy_set[63:0], exp vld[3:0], exp waves {p3,p2,p1,p0}[15:0], exp blk[15:0]}
    localparam logic [99:0] TBL [10] = '{
        {64'h0000_0008_0000_0002, 4'h4, 16'h0300, 16'h0008},  // R5 same SIMD, same bank
        {64'h0000_0004_0000_0002, 4'h5, 16'h0201, 16'h0006},  // R6 other bank
        {64'h0002_0000_0200_0000, 4'hA, 16'h1090, 16'h0202},  // R6 other SIMD
        {64'h0400_0100_0000_0000, 4'h4, 16'h0800, 16'h0100},  // R8 memory cancels memory
        {64'h0000_0010_0004_0001, 4'h6, 16'h0420, 16'h0014},  // R7 single drop per memory pipe
        {64'h0040_0010_0004_0001, 4'hC, 16'h6400, 16'h0050},  // R7 second memory pipe skips dropped slot
        {64'h0004_0001_0000_0010, 4'h8, 16'h2000, 16'h0004},  // R8 chain
        {64'h0000_0000_0000_1028, 4'h1, 16'h0003, 16'h0008},  // R2 lowest id after reset
        {64'h0000_0000_0000_0000, 4'h0, 16'h0000, 16'h0000},  // R1 nothing ready
        {64'h0000_0800_0000_0008, 4'h5, 16'h0B03, 16'h0808}   // R6 same bank, other SIMD
    };

    function automatic string row_req(int i);
        case (i)
            0: return "R5";
            1, 2, 9: return "R6";
            3, 6: return "R8";
            4, 5: return "R7";
            7: return "R2";
            default: return "R1";
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        rdy_set = '0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic chk(string req, logic [3:0] ev, logic [15:0] ew, logic [15:0] eb);
        logic [3:0] es;
        for (int p = 0; p < P; p++) es[p] = ew[p*4+3];
        n_chk++;
        if ({disp_vld, disp_wave, disp_simd} !== {ev, ew, es}) begin
            n_fail++;
            $display("FAIL %s dispatch: got vld=%h wave=%h simd=%h, expected vld=%h wave=%h simd=%h",
                     req, disp_vld, disp_wave, disp_simd, ev, ew, es);
        end
        n_chk++;
        if (wave_blk !== eb) begin
            n_fail++;
            $display("FAIL %s blocked: got %h, expected %h", req, wave_blk, eb);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R10", 4'h0, 16'h0000, 16'h0000);

        for (int i = 0; i < 10; i++) begin
            do_reset();
            rdy_set = TBL[i][99:36];
            tick();
            rdy_set = '0;
            tick();
            chk(row_req(i), TBL[i][35:32], TBL[i][31:16], TBL[i][15:0]);
        end

        // R2 order and wrap, R3 hold, R4 blocked flag
        do_reset();
        rdy_set = 64'h1028;
        tick();
        rdy_set = '0;
        tick();
        chk("R2", 4'h1, 16'h0003, 16'h0008);
        tick();
        chk("R2", 4'h1, 16'h0005, 16'h0028);
        tick();
        chk("R4", 4'h1, 16'h000C, 16'h1028);
        tick();
        chk("R3", 4'h1, 16'h000C, 16'h1028);
        rdy_set = 64'h0008;
        tick();
        rdy_set = '0;
        chk("R4", 4'h1, 16'h000C, 16'h1020);
        tick();
        chk("R2", 4'h1, 16'h0003, 16'h1028);

        // R9 cancelled wave competes again; R3 memory slot held
        do_reset();
        rdy_set = 64'h0000_0008_0000_0006;
        tick();
        rdy_set = '0;
        tick();
        chk("R5", 4'h4, 16'h0300, 16'h0008);
        tick();
        chk("R3", 4'h5, 16'h0302, 16'h000C);
        tick();
        chk("R9", 4'h4, 16'h0300, 16'h000C);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule